// File: doc/BRIEF.md
# Per-Core IRQ/FIQ Interrupt Router

The router takes a set of level-sensitive interrupt requests that belong to a cluster of four processor cores and steers each one to either the normal-priority (IRQ) line or the fast (FIQ) line of a core, or drops it. Every core owns four timer requests and four mailbox requests. One graphics-unit request is shared by the cluster and is pointed at a single core. One performance-monitor request is shared and enabled per core. The timers, the mailbox storage and the request producers sit outside this block. Only their request lines enter it.

Software configures the router through a 32-bit register bus with a write strobe and a combinational read port. Each core has one enable register for its timers and one for its mailboxes. A routing register places the graphics request. The performance-monitor enables sit behind a set address and a clear address. Each core also has two read-only status words, one for IRQ and one for FIQ. These words show which requests are currently routed to that core's lines.

The bus has no valid/ready handshake and no back-pressure. A write is accepted on the clock edge where the write strobe is high. Read data reflects the addressed register in the same cycle. The request inputs and the core outputs are plain level signals with no flow control.

Top module: `irq_router`

## Requirements
- R1: After reset every enable register, the graphics routing register and the performance-monitor mask read 0. In that state no timer, mailbox or performance-monitor request reaches any output. A graphics request drives the IRQ of core 0.
- R2: The timer enable register of core c is at 0x040+4c and the mailbox enable register is at 0x050+4c. Bits [3:0] are the IRQ enables of sources 0–3 and bits [7:4] are their FIQ enables. Bits [7:0] read back as written, higher bits read 0, and a register changes only when it is written.
- R3: A request whose FIQ enable is set appears in its core's FIQ status and never in its IRQ status, whatever its IRQ enable holds. A request with only its IRQ enable set appears in the IRQ status only.
- R4: The IRQ status of core c reads at 0x060+4c and the FIQ status at 0x070+4c. Bit t is timer t, bit 4+m is mailbox m, bit 8 is the graphics request and bit 9 is the performance-monitor request. The status follows the request levels in the same cycle.
- R5: Writes to the status addresses change no register and no status bit.
- R6: The routing register at 0x00C holds the IRQ target core in bits [1:0], the FIQ target core in bits [3:2] and the FIQ select in bit 4. When bit 4 is 0 the graphics request reaches the IRQ of the IRQ target core. When bit 4 is 1 it reaches the FIQ of the FIQ target core. A graphics request is routed to exactly one core.
- R7: Writing 0x010 sets every mask bit whose data bit is 1 and leaves the other bits unchanged. Mask bit n (0–3) enables the performance-monitor IRQ of core n. Mask bit 4+n enables its FIQ on core n, and the FIQ enable takes precedence over the IRQ enable.
- R8: Writing 0x014 clears every mask bit whose data bit is 1. Reading either 0x010 or 0x014 returns the 8-bit mask.
- R9: Each core's IRQ output is high exactly when its IRQ status is non-zero. Its FIQ output is high exactly when its FIQ status is non-zero.
- R10: With no request asserted every output is low. Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| timer_req | input | 16 | Timer requests, bit 4c+t is timer t of core c |
| mbox_req | input | 16 | Mailbox requests, bit 4c+m is mailbox m of core c |
| gpu_req | input | 1 | Shared graphics-unit request |
| pmu_req | input | 1 | Shared performance-monitor request |
| core_irq | output | 4 | IRQ line per core |
| core_fiq | output | 4 | FIQ line per core |

## Verification
The assertions check several properties on every cycle. No source is ever pending on both the IRQ and FIQ of a core. Idle inputs give quiet outputs. A graphics request lands on exactly one core. The performance-monitor set and clear writes move only the addressed bits. Enable registers hold when no write occurs, and status-address writes disturb nothing. The bench scenarios show what the properties cannot. They confirm that each bit position and address from the layout maps to the intended source and core. They confirm the reset routing of the graphics request, readback truncation, and that unmapped writes are ignored.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NCORE   = 4;              // cores served
  localparam int NSRC    = 4;              // timers (and mailboxes) per core
  localparam int CTL_W   = 2 * NSRC;       // IRQ enables low, FIQ enables high
  localparam int PEND_W  = 2 * NSRC + 2;   // timers, mailboxes, gpu, pmu
  localparam int PB_MBX  = NSRC;
  localparam int PB_GPU  = 2 * NSRC;
  localparam int PB_PMU  = 2 * NSRC + 1;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int CI_W    = $clog2(NCORE);
  localparam int ROUTE_W = 2 * CI_W + 1;
  localparam int MASK_W  = 2 * NCORE;

  localparam int A_ROUTE    = 'h00C;
  localparam int A_PMU_SET  = 'h010;
  localparam int A_PMU_CLR  = 'h014;
  localparam int A_TMR_BASE = 'h040;
  localparam int A_MBX_BASE = 'h050;
  localparam int A_IRQ_BASE = 'h060;
  localparam int A_FIQ_BASE = 'h070;
  localparam int STRIDE     = 4;
endpackage

// File: rtl/irq_router_grp.sv
module irq_router_grp #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  input  logic [W-1:0] irq_en,
  input  logic [W-1:0] fiq_en,
  output logic [W-1:0] irq_hit,
  output logic [W-1:0] fiq_hit
);
  // FIQ enable wins over IRQ enable for each source bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fiq_hit[i] = req[i] & fiq_en[i];
    assign irq_hit[i] = req[i] & irq_en[i] & ~fiq_en[i];
  end
endmodule

// File: rtl/irq_router_steer.sv
module irq_router_steer
  import irq_router_pkg::*;
(
  input  logic [NSRC-1:0]   tmr_req,
  input  logic [NSRC-1:0]   mbx_req,
  input  logic [CTL_W-1:0]  tmr_ctl,
  input  logic [CTL_W-1:0]  mbx_ctl,
  input  logic              gpu_irq_hit,
  input  logic              gpu_fiq_hit,
  input  logic              pmu_req,
  input  logic              pmu_irq_en,
  input  logic              pmu_fiq_en,
  output logic [PEND_W-1:0] irq_pend,
  output logic [PEND_W-1:0] fiq_pend,
  output logic              irq_out,
  output logic              fiq_out
);
  logic [NSRC-1:0] tmr_i, tmr_f, mbx_i, mbx_f;
  logic            pmu_i, pmu_f;

  irq_router_grp #(.W(NSRC)) u_tmr (
    .req(tmr_req), .irq_en(tmr_ctl[NSRC-1:0]), .fiq_en(tmr_ctl[CTL_W-1:NSRC]),
    .irq_hit(tmr_i), .fiq_hit(tmr_f)
  );

  irq_router_grp #(.W(NSRC)) u_mbx (
    .req(mbx_req), .irq_en(mbx_ctl[NSRC-1:0]), .fiq_en(mbx_ctl[CTL_W-1:NSRC]),
    .irq_hit(mbx_i), .fiq_hit(mbx_f)
  );

  irq_router_grp #(.W(1)) u_pmu (
    .req(pmu_req), .irq_en(pmu_irq_en), .fiq_en(pmu_fiq_en),
    .irq_hit(pmu_i), .fiq_hit(pmu_f)
  );

  assign irq_pend = {pmu_i, gpu_irq_hit, mbx_i, tmr_i};
  assign fiq_pend = {pmu_f, gpu_fiq_hit, mbx_f, tmr_f};
  assign irq_out  = |irq_pend;
  assign fiq_out  = |fiq_pend;
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [CTL_W-1:0]             wdata,
  input  logic [NCORE-1:0][PEND_W-1:0] irq_pend,
  input  logic [NCORE-1:0][PEND_W-1:0] fiq_pend,
  output logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl,
  output logic [NCORE-1:0][CTL_W-1:0]  mbx_ctl,
  output logic [ROUTE_W-1:0]           gpu_route,
  output logic [MASK_W-1:0]            pmu_mask,
  output logic [DATA_W-1:0]            rdata
);
  // per-core enable registers
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam logic [ADDR_W-1:0] TMR_A = ADDR_W'(A_TMR_BASE + STRIDE * c);
    localparam logic [ADDR_W-1:0] MBX_A = ADDR_W'(A_MBX_BASE + STRIDE * c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_ctl[c] <= '0;
        mbx_ctl[c] <= '0;
      end else if (wr_en) begin
        if (addr == TMR_A) tmr_ctl[c] <= wdata;
        if (addr == MBX_A) mbx_ctl[c] <= wdata;
      end
    end
  end

  // shared routing and performance-monitor mask
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpu_route <= '0;
      pmu_mask  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_ROUTE))   gpu_route <= wdata[ROUTE_W-1:0];
      if (addr == ADDR_W'(A_PMU_SET)) pmu_mask  <= pmu_mask | wdata[MASK_W-1:0];
      if (addr == ADDR_W'(A_PMU_CLR)) pmu_mask  <= pmu_mask & ~wdata[MASK_W-1:0];
    end
  end

  // combinational read port
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_ROUTE)) rdata[ROUTE_W-1:0] = gpu_route;
    if (addr == ADDR_W'(A_PMU_SET) || addr == ADDR_W'(A_PMU_CLR))
      rdata[MASK_W-1:0] = pmu_mask;
    for (int c = 0; c < NCORE; c++) begin
      if (addr == ADDR_W'(A_TMR_BASE + STRIDE * c)) rdata[CTL_W-1:0]  = tmr_ctl[c];
      if (addr == ADDR_W'(A_MBX_BASE + STRIDE * c)) rdata[CTL_W-1:0]  = mbx_ctl[c];
      if (addr == ADDR_W'(A_IRQ_BASE + STRIDE * c)) rdata[PEND_W-1:0] = irq_pend[c];
      if (addr == ADDR_W'(A_FIQ_BASE + STRIDE * c)) rdata[PEND_W-1:0] = fiq_pend[c];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCORE*NSRC-1:0] timer_req,
  input  logic [NCORE*NSRC-1:0] mbox_req,
  input  logic              gpu_req,
  input  logic              pmu_req,
  output logic [NCORE-1:0]  core_irq,
  output logic [NCORE-1:0]  core_fiq
);
  logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl;
  logic [NCORE-1:0][CTL_W-1:0]  mbx_ctl;
  logic [NCORE-1:0][PEND_W-1:0] irq_pend;
  logic [NCORE-1:0][PEND_W-1:0] fiq_pend;
  logic [ROUTE_W-1:0]           gpu_route;
  logic [MASK_W-1:0]            pmu_mask;
  logic [NCORE-1:0]             gpu_irq_hit, gpu_fiq_hit;
  logic [CI_W-1:0]              gpu_irq_core, gpu_fiq_core;
  logic                         gpu_fiq_mode;
  logic                         unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTL_W];

  irq_router_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata[CTL_W-1:0]), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
    .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .gpu_route(gpu_route),
    .pmu_mask(pmu_mask), .rdata(bus_rdata)
  );

  assign gpu_irq_core = gpu_route[CI_W-1:0];
  assign gpu_fiq_core = gpu_route[2*CI_W-1:CI_W];
  assign gpu_fiq_mode = gpu_route[2*CI_W];

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    assign gpu_irq_hit[c] = gpu_req & ~gpu_fiq_mode & (gpu_irq_core == CI_W'(c));
    assign gpu_fiq_hit[c] = gpu_req &  gpu_fiq_mode & (gpu_fiq_core == CI_W'(c));

    irq_router_steer u_steer (
      .tmr_req(timer_req[c*NSRC +: NSRC]),
      .mbx_req(mbox_req[c*NSRC +: NSRC]),
      .tmr_ctl(tmr_ctl[c]),
      .mbx_ctl(mbx_ctl[c]),
      .gpu_irq_hit(gpu_irq_hit[c]),
      .gpu_fiq_hit(gpu_fiq_hit[c]),
      .pmu_req(pmu_req),
      .pmu_irq_en(pmu_mask[c]),
      .pmu_fiq_en(pmu_mask[NCORE + c]),
      .irq_pend(irq_pend[c]),
      .fiq_pend(fiq_pend[c]),
      .irq_out(core_irq[c]),
      .fiq_out(core_fiq[c])
    );
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_wr,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [MASK_W-1:0]            wdata_lo,
  input logic [NCORE*NSRC-1:0]        timer_req,
  input logic [NCORE*NSRC-1:0]        mbox_req,
  input logic                         gpu_req,
  input logic                         pmu_req,
  input logic [NCORE-1:0]             core_irq,
  input logic [NCORE-1:0]             core_fiq,
  input logic [NCORE-1:0][PEND_W-1:0] irq_pend,
  input logic [NCORE-1:0][PEND_W-1:0] fiq_pend,
  input logic [NCORE-1:0][CTL_W-1:0]  tmr_ctl,
  input logic [NCORE-1:0][CTL_W-1:0]  mbx_ctl,
  input logic [MASK_W-1:0]            pmu_mask
);
  logic [NCORE-1:0] gpu_seen;
  logic             idle_in, pend_wr;

  always_comb begin
    for (int c = 0; c < NCORE; c++)
      gpu_seen[c] = irq_pend[c][PB_GPU] | fiq_pend[c][PB_GPU];
  end
  assign idle_in = (timer_req == '0) && (mbox_req == '0) && !gpu_req && !pmu_req;
  assign pend_wr = bus_wr && (bus_addr >= ADDR_W'(A_IRQ_BASE))
                          && (bus_addr <  ADDR_W'(A_FIQ_BASE + STRIDE * NCORE));

  // R3
  fiq_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend & fiq_pend) == '0);

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_in |-> (core_irq == '0) && (core_fiq == '0));

  // R6
  gpu_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpu_req |-> $countones(gpu_seen) == 1);

  // R6
  gpu_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gpu_req |-> gpu_seen == '0);

  // R7
  pmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_PMU_SET))
      |=> ((pmu_mask & $past(wdata_lo)) == $past(wdata_lo))
       && ((pmu_mask & ~$past(wdata_lo)) == ($past(pmu_mask) & ~$past(wdata_lo))));

  // R8
  pmu_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_PMU_CLR))
      |=> ((pmu_mask & $past(wdata_lo)) == '0)
       && ((pmu_mask & ~$past(wdata_lo)) == ($past(pmu_mask) & ~$past(wdata_lo))));

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(tmr_ctl) && $stable(mbx_ctl) && $stable(pmu_mask));

  // R5
  pend_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr |=> $stable(tmr_ctl) && $stable(mbx_ctl) && $stable(pmu_mask));
endmodule

bind irq_router irq_router_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[irq_router_pkg::MASK_W-1:0]),
  .timer_req(timer_req), .mbox_req(mbox_req), .gpu_req(gpu_req), .pmu_req(pmu_req),
  .core_irq(core_irq), .core_fiq(core_fiq),
  .irq_pend(irq_pend), .fiq_pend(fiq_pend),
  .tmr_ctl(tmr_ctl), .mbx_ctl(mbx_ctl), .pmu_mask(pmu_mask)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] timer_req, mbox_req;
  logic        gpu_req, pmu_req;
  logic [3:0]  core_irq, core_fiq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rv;
  logic [41:0] vec;

  always #10 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_req(timer_req), .mbox_req(mbox_req), .gpu_req(gpu_req), .pmu_req(pmu_req),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  // {timer, mbox, gpu, pmu, expected irq, expected fiq}
  // config: core0 timer ctl 0x13, core1 mbox ctl 0x84, route 0x0B, pmu mask 0x24
  localparam int NVEC = 11;
  localparam logic [41:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h0},
    {16'h0001, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h1},
    {16'h0002, 16'h0000, 1'b0, 1'b0, 4'h1, 4'h0},
    {16'h0004, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h0},
    {16'h0010, 16'h0000, 1'b0, 1'b0, 4'h0, 4'h0},
    {16'h0000, 16'h0040, 1'b0, 1'b0, 4'h2, 4'h0},
    {16'h0000, 16'h0080, 1'b0, 1'b0, 4'h0, 4'h2},
    {16'h0000, 16'h0004, 1'b0, 1'b0, 4'h0, 4'h0},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 4'h8, 4'h0},
    {16'h0000, 16'h0000, 1'b0, 1'b1, 4'h4, 4'h2},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 4'hF, 4'h3}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic drive(input logic [15:0] t, input logic [15:0] m, input logic g, input logic p);
    @(negedge clk);
    timer_req = t; mbox_req = m; gpu_req = g; pmu_req = p;
    #2;
  endtask

  task automatic outs(input string tag, input logic [3:0] ei, input logic [3:0] ef);
    check({tag, " irq"}, {28'd0, core_irq}, {28'd0, ei});
    check({tag, " fiq"}, {28'd0, core_fiq}, {28'd0, ef});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    timer_req = '0; mbox_req = '0; gpu_req = 1'b0; pmu_req = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4 * c), rv); check("R1 timer ctl reset", rv, 32'h0);
      rd(8'h50 + 8'(4 * c), rv); check("R1 mbox ctl reset", rv, 32'h0);
    end
    rd(8'h0C, rv); check("R1 route reset", rv, 32'h0);
    rd(8'h10, rv); check("R1 pmu mask reset", rv, 32'h0);
    drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    outs("R1 reset routing", 4'h1, 4'h0);
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    outs("R10 idle", 4'h0, 4'h0);

    // configuration for the vector table
    wr(8'h40, 32'h0000_0013);
    wr(8'h54, 32'h0000_0084);
    wr(8'h0C, 32'h0000_000B);
    wr(8'h10, 32'h0000_0024);
    rd(8'h40, rv); check("R2 timer ctl readback", rv, 32'h13);
    rd(8'h54, rv); check("R2 mbox ctl readback", rv, 32'h84);

    // R3 R6 R7 R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      vec = VEC[i];
      drive(vec[41:26], vec[25:10], vec[9], vec[8]);
      outs($sformatf("R9 R3 vector %0d", i), vec[7:4], vec[3:0]);
    end

    // R4 status words
    drive(16'h0003, 16'h0000, 1'b0, 1'b0);
    rd(8'h60, rv); check("R4 core0 irq status", rv, 32'h002);
    rd(8'h70, rv); check("R4 core0 fiq status", rv, 32'h001);
    drive(16'h0000, 16'h00C0, 1'b0, 1'b0);
    rd(8'h64, rv); check("R4 core1 irq status", rv, 32'h040);
    rd(8'h74, rv); check("R4 core1 fiq status", rv, 32'h080);
    drive(16'h0000, 16'h00C0, 1'b1, 1'b1);
    rd(8'h68, rv); check("R4 core2 irq status pmu", rv, 32'h200);
    rd(8'h74, rv); check("R4 core1 fiq status pmu", rv, 32'h280);
    rd(8'h6C, rv); check("R4 core3 irq status gpu", rv, 32'h100);

    // R5 status words are read-only
    drive(16'h0, 16'h0, 1'b0, 1'b0);
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h40, rv); check("R5 ctl after status write", rv, 32'h13);
    rd(8'h10, rv); check("R5 mask after status write", rv, 32'h24);
    rd(8'h60, rv); check("R5 status after write", rv, 32'h0);
    outs("R5 outputs after status write", 4'h0, 4'h0);

    // R6 FIQ select for the graphics request
    wr(8'h0C, 32'h0000_001B);
    drive(16'h0, 16'h0, 1'b1, 1'b0);
    outs("R6 gpu to fiq core2", 4'h0, 4'h4);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, rv); check("R6 route truncation", rv, 32'h1F);
    outs("R6 gpu to fiq core3", 4'h0, 4'h8);
    wr(8'h0C, 32'h0000_0001);
    outs("R6 gpu to irq core1", 4'h2, 4'h0);

    // R7 R8 mask set and clear
    drive(16'h0, 16'h0, 1'b0, 1'b1);
    wr(8'h14, 32'h0000_0004);
    rd(8'h10, rv); check("R8 clear one bit", rv, 32'h20);
    outs("R8 pmu after clear", 4'h0, 4'h2);
    wr(8'h10, 32'h0000_0001);
    rd(8'h14, rv); check("R7 set keeps others", rv, 32'h21);
    outs("R7 pmu after set", 4'h1, 4'h2);
    wr(8'h10, 32'h0000_0010);
    outs("R7 pmu fiq wins core0", 4'h0, 4'h3);
    wr(8'h14, 32'h0000_00FF);
    rd(8'h10, rv); check("R8 clear all", rv, 32'h0);
    outs("R8 pmu disabled", 4'h0, 4'h0);

    // R10 unmapped address
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, rv); check("R10 unmapped read", rv, 32'h0);
    rd(8'h40, rv); check("R10 ctl after unmapped write", rv, 32'h13);

    // R2 truncation and R3 override on core3
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, rv); check("R2 upper bits dropped", rv, 32'hFF);
    drive(16'h8000, 16'h0, 1'b0, 1'b0);
    outs("R3 both enables fiq wins", 4'h0, 4'h8);
    rd(8'h6C, rv); check("R3 irq status clear", rv, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule